// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Loader

This block loads a configuration bitstream into a target FPGA over a slave-serial link. A single start pulse begins a load. The block pulls the target's program pin low for a fixed number of cycles and then releases it. It then waits for the target to raise its INIT line. After that it takes bitstream bytes from a valid/ready stream and shifts each one out bit by bit, most significant bit first, on a slow configuration clock. The upstream source marks the final byte of the stream.

After the last bit the block samples the target's INIT and DONE lines once. The load can end in one of four ways. If INIT is low, the target saw a CRC error. If INIT is high but DONE is low, the target never finished. If the target is healthy, the block sends four extra configuration clocks and pulses an active-low user reset, then reports success. If INIT never rises after the program pulse, the load aborts with a timeout. The result flags keep their value until the next start, so a host can poll them.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset and before any start, `cfg_prog_n` and `user_rst_n` are high, and `cfg_cclk`, `busy`, `byte_ready` and all four result flags are low.
- R2: A start accepted while idle drives `cfg_prog_n` low for exactly `PROG_LOW_CYC` cycles. During that time `cfg_cclk` is low, `user_rst_n` is high and `byte_ready` is low.
- R3: After the program pin is released, the block waits for `cfg_init` to be high. If `cfg_init` stays low for `INIT_TO_CYC` cycles, the load ends with `fail_timeout` set. No configuration clock edge is issued and no byte is requested in that case.
- R4: Each bit is presented on `cfg_din` while `cfg_cclk` is low, for at least `HALF_DIV` cycles. The clock is then high for exactly `HALF_DIV` cycles, and `cfg_din` does not change while the clock is high.
- R5: Every bit of every accepted byte is sent in order, most significant bit first. One rising edge of `cfg_cclk` carries each bit.
- R6: `byte_ready` is high only when the next byte is needed. It stays high until `byte_valid` is seen and drops in the cycle after a byte is accepted. Exactly one byte is accepted for each group of eight bits sent.
- R7: After the last bit of the byte marked by `byte_last`, if `cfg_init` is low the load ends with `fail_crc`. No trailing clocks and no user reset pulse follow.
- R8: After the last bit, if `cfg_init` is high and `cfg_done` is low, the load ends with `fail_notdone`. No trailing clocks follow.
- R9: After the last bit, if `cfg_init` and `cfg_done` are both high, exactly `TRAIL_CLKS` (four) further rising edges of `cfg_cclk` follow. Then `user_rst_n` goes low for exactly `RST_LOW_CYC` cycles, and then `load_ok` is set.
- R10: The result flags are all cleared while a load is running. Once a load ends, they hold their value until the next start. At most one flag is set at a time. A start received while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a load (used only while idle) |
| byte_data | input | 8 | Bitstream byte |
| byte_valid | input | 1 | `byte_data` holds a valid byte |
| byte_last | input | 1 | The offered byte is the final one of the bitstream |
| byte_ready | output | 1 | The loader accepts a byte in this cycle |
| cfg_init | input | 1 | Target INIT line (high = ready, low after the last bit = CRC error) |
| cfg_done | input | 1 | Target DONE line |
| cfg_prog_n | output | 1 | Target program pin, active low |
| cfg_cclk | output | 1 | Configuration clock; the target captures on the rising edge |
| cfg_din | output | 1 | Serial configuration data |
| user_rst_n | output | 1 | Active-low reset pulse sent after a successful load |
| busy | output | 1 | A load is in progress |
| load_ok | output | 1 | The last load completed successfully |
| fail_timeout | output | 1 | The last load aborted because INIT did not rise |
| fail_crc | output | 1 | The last load ended with INIT low (CRC error) |
| fail_notdone | output | 1 | The last load ended with INIT high but DONE low |

## Verification
The assertions check the local rules on every cycle:
- the serial data holds steady while the configuration clock is high;
- the ready signal holds until a byte arrives and drops after a handshake;
- the program pulse stays clear of clock, reset and ready activity;
- each result flag matches the INIT and DONE values seen in the cycle before it is raised;
- the result flags are mutually exclusive and hold still while idle.

Only the scenarios can show the properties that span a whole load:
- the exact widths of the program and reset pulses;
- bit order and completeness, checked against a scoreboard of expected bits;
- the trailing clock count;
- the timeout duration;
- that a start during a load is ignored.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_FETCH,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_CHECK,
        ST_TRAIL_LO,
        ST_TRAIL_HI,
        ST_USER_RST
    } ld_state_e;

    typedef struct packed {
        logic ok;
        logic timeout;
        logic crc;
        logic notdone;
    } ld_result_t;

endpackage

// File: rtl/cfg_cycle_cnt.sv
// Saturating cycle counter: hit is high in the last of lim cycles after clr.
module cfg_cycle_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] lim,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   nxt;

    assign nxt = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    assign hit = (nxt >= {1'b0, lim});

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (!hit) begin
            cnt_d = nxt[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/cfg_byte_shift.sv
// Parallel-load shift register, MSB first, with a bit position counter.
module cfg_byte_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb,
    output logic         last_bit
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0]  data;
        logic [CW-1:0] cnt;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.data = din;
            s_d.cnt  = '0;
        end else if (shift) begin
            s_d.data = {s_q.data[W-2:0], 1'b0};
            s_d.cnt  = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign msb      = s_q.data[W-1];
    assign last_bit = (s_q.cnt == CW'(W - 1));

    // R5: a byte is never reloaded in the same cycle it is being advanced
    p_no_load_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int PROG_LOW_CYC = 80,
    parameter int INIT_TO_CYC  = 1250000,
    parameter int HALF_DIV     = 4,
    parameter int RST_LOW_CYC  = 64,
    parameter int TRAIL_CLKS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              byte_valid,
    input  logic              byte_last,
    output logic              byte_ready,
    input  logic              cfg_init,
    input  logic              cfg_done,
    output logic              cfg_prog_n,
    output logic              cfg_cclk,
    output logic              cfg_din,
    output logic              user_rst_n,
    output logic              busy,
    output logic              load_ok,
    output logic              fail_timeout,
    output logic              fail_crc,
    output logic              fail_notdone
);
    localparam int MAX_PR   = (PROG_LOW_CYC > RST_LOW_CYC) ? PROG_LOW_CYC : RST_LOW_CYC;
    localparam int LONG_MAX = (INIT_TO_CYC > MAX_PR) ? INIT_TO_CYC : MAX_PR;
    localparam int LW       = $clog2(LONG_MAX + 1);
    localparam int HW       = $clog2(HALF_DIV + 1);
    localparam int TW       = (TRAIL_CLKS > 1) ? $clog2(TRAIL_CLKS) : 1;
    localparam logic [HW-1:0] HALF_LIM = HW'(HALF_DIV);
    localparam logic [TW-1:0] TRAIL_END = TW'(TRAIL_CLKS - 1);

    typedef struct packed {
        ld_state_e        st;
        logic             last;
        logic [TW-1:0]    trail;
        ld_result_t       res;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          half_clr, half_hit;
    logic          long_clr, long_hit;
    logic [LW-1:0] long_lim;
    logic          sh_load, sh_shift, sh_msb, sh_last;

    // half-period timer for the configuration clock
    cfg_cycle_cnt #(.W(HW)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (half_clr),
        .lim   (HALF_LIM),
        .hit   (half_hit)
    );

    // long timer: program pulse, INIT timeout, user reset pulse
    cfg_cycle_cnt #(.W(LW)) u_long (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (long_clr),
        .lim   (long_lim),
        .hit   (long_hit)
    );

    cfg_byte_shift #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .shift    (sh_shift),
        .din      (byte_data),
        .msb      (sh_msb),
        .last_bit (sh_last)
    );

    always_comb begin
        c_d      = c_q;
        half_clr = 1'b0;
        long_clr = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        long_lim = LW'(PROG_LOW_CYC);
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.res  = '0;
                    c_d.st   = ST_PROG;
                    long_clr = 1'b1;
                end
            end
            ST_PROG: begin
                if (long_hit) begin
                    c_d.st   = ST_WAIT_INIT;
                    long_clr = 1'b1;
                end
            end
            ST_WAIT_INIT: begin
                long_lim = LW'(INIT_TO_CYC);
                if (cfg_init) begin
                    c_d.st = ST_FETCH;
                end else if (long_hit) begin
                    c_d.res.timeout = 1'b1;
                    c_d.st          = ST_IDLE;
                end
            end
            ST_FETCH: begin
                if (byte_valid) begin
                    sh_load  = 1'b1;
                    c_d.last = byte_last;
                    c_d.st   = ST_BIT_LO;
                    half_clr = 1'b1;
                end
            end
            ST_BIT_LO: begin
                if (half_hit) begin
                    c_d.st   = ST_BIT_HI;
                    half_clr = 1'b1;
                end
            end
            ST_BIT_HI: begin
                if (half_hit) begin
                    if (sh_last) begin
                        c_d.st = c_q.last ? ST_CHECK : ST_FETCH;
                    end else begin
                        sh_shift = 1'b1;
                        c_d.st   = ST_BIT_LO;
                        half_clr = 1'b1;
                    end
                end
            end
            ST_CHECK: begin
                if (!cfg_init) begin
                    c_d.res.crc = 1'b1;
                    c_d.st      = ST_IDLE;
                end else if (!cfg_done) begin
                    c_d.res.notdone = 1'b1;
                    c_d.st          = ST_IDLE;
                end else begin
                    c_d.trail = '0;
                    c_d.st    = ST_TRAIL_LO;
                    half_clr  = 1'b1;
                end
            end
            ST_TRAIL_LO: begin
                if (half_hit) begin
                    c_d.st   = ST_TRAIL_HI;
                    half_clr = 1'b1;
                end
            end
            ST_TRAIL_HI: begin
                if (half_hit) begin
                    if (c_q.trail == TRAIL_END) begin
                        c_d.st   = ST_USER_RST;
                        long_clr = 1'b1;
                    end else begin
                        c_d.trail = c_q.trail + 1'b1;
                        c_d.st    = ST_TRAIL_LO;
                        half_clr  = 1'b1;
                    end
                end
            end
            ST_USER_RST: begin
                long_lim = LW'(RST_LOW_CYC);
                if (long_hit) begin
                    c_d.res.ok = 1'b1;
                    c_d.st     = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, last: 1'b0, trail: '0, res: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign cfg_prog_n   = (c_q.st != ST_PROG);
    assign cfg_cclk     = (c_q.st == ST_BIT_HI) || (c_q.st == ST_TRAIL_HI);
    assign cfg_din      = sh_msb;
    assign user_rst_n   = (c_q.st != ST_USER_RST);
    assign busy         = (c_q.st != ST_IDLE);
    assign byte_ready   = (c_q.st == ST_FETCH);
    assign load_ok      = c_q.res.ok;
    assign fail_timeout = c_q.res.timeout;
    assign fail_crc     = c_q.res.crc;
    assign fail_notdone = c_q.res.notdone;

    // R4: serial data steady while the configuration clock is high
    p_din_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cclk && $past(cfg_cclk)) |-> $stable(cfg_din));

    // R6: ready waits for a byte, then drops after the handshake
    p_ready_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ready && !byte_valid) |=> byte_ready);
    p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ready && byte_valid) |=> !byte_ready);

    // R2: program pulse is quiet on clock, user reset and stream
    p_prog_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_prog_n |-> (!cfg_cclk && user_rst_n && !byte_ready));

    // R3: timeout only after INIT seen low, and the load is over
    p_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_timeout) |-> ($past(!cfg_init) && !busy));

    // R7: CRC result follows INIT low at the check
    p_crc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_crc) |-> $past(!cfg_init));

    // R8: not-done result follows INIT high with DONE low
    p_notdone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_notdone) |-> $past(cfg_init && !cfg_done));

    // R9: user reset begins right after a trailing clock high phase
    p_rst_after_trail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(user_rst_n) |-> $past(cfg_cclk));

    // R10: flags exclusive, cleared while busy, held while idle
    p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_ok, fail_timeout, fail_crc, fail_notdone}));
    p_busy_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(load_ok || fail_timeout || fail_crc || fail_notdone));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(load_ok) && $stable(fail_timeout) &&
                               $stable(fail_crc) && $stable(fail_notdone)));

endmodule

// File: tb/tb_fpga_cfg_loader.sv
`timescale 1ns/1ps
module tb_fpga_cfg_loader;
    localparam int TB_PROG  = 10;
    localparam int TB_TO    = 200;
    localparam int TB_HALF  = 2;
    localparam int TB_RST   = 6;
    localparam int TB_TRAIL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic byte_valid = 1'b0;
    logic byte_last = 1'b0;
    logic byte_ready, cfg_prog_n, cfg_cclk, cfg_din, user_rst_n, busy;
    logic load_ok, fail_timeout, fail_crc, fail_notdone;
    logic cfg_init, cfg_done;

    always #2 clk = ~clk;

    fpga_cfg_loader #(
        .DATA_W(8), .PROG_LOW_CYC(TB_PROG), .INIT_TO_CYC(TB_TO),
        .HALF_DIV(TB_HALF), .RST_LOW_CYC(TB_RST), .TRAIL_CLKS(TB_TRAIL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_last(byte_last),
        .byte_ready(byte_ready), .cfg_init(cfg_init), .cfg_done(cfg_done),
        .cfg_prog_n(cfg_prog_n), .cfg_cclk(cfg_cclk), .cfg_din(cfg_din),
        .user_rst_n(user_rst_n), .busy(busy), .load_ok(load_ok),
        .fail_timeout(fail_timeout), .fail_crc(fail_crc), .fail_notdone(fail_notdone)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- target model ----------------
    logic tgt_init = 1'b0;
    logic tgt_prev = 1'b0;
    int   tgt_rise = 0;
    int   tgt_dly  = 0;
    int   tgt_bits = 1000000;
    bit   tgt_never = 1'b0;
    bit   tgt_crc = 1'b0;
    bit   tgt_done_en = 1'b1;

    always @(posedge clk) begin
        tgt_prev <= cfg_cclk;
        if (!cfg_prog_n) begin
            tgt_init <= 1'b0;
            tgt_dly  <= 0;
            tgt_rise <= 0;
        end else begin
            if (cfg_cclk && !tgt_prev) tgt_rise <= tgt_rise + 1;
            if (!tgt_init && !tgt_never && tgt_rise == 0) begin
                if (tgt_dly == 5) tgt_init <= 1'b1;
                else tgt_dly <= tgt_dly + 1;
            end
            if (tgt_crc && tgt_rise >= tgt_bits) tgt_init <= 1'b0;
        end
    end
    assign cfg_init = tgt_init;
    assign cfg_done = tgt_done_en && (tgt_rise >= tgt_bits);

    // ---------------- scoreboard monitor ----------------
    bit   exp_q[$];
    logic mon_cclk = 1'b0;
    logic mon_prog = 1'b1;
    logic mon_urst = 1'b1;
    int   hi_len = 0, lo_len = 0;
    int   plen = 0, rlen = 0, last_plen = 0, last_rlen = 0;
    int   prog_pulses = 0, rst_pulses = 0, rises = 0, trail_seen = 0, hs = 0;

    always @(posedge clk) begin
        if (rst_n && byte_ready && byte_valid) hs <= hs + 1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_cclk && !mon_cclk) begin
                rises++;
                chk(lo_len >= TB_HALF, "R4 low phase length", lo_len, TB_HALF);
                if (exp_q.size() > 0) begin
                    bit b;
                    b = exp_q.pop_front();
                    chk(cfg_din == b, "R5 serial bit", int'(cfg_din), int'(b));
                end else begin
                    trail_seen++;
                end
            end
            if (cfg_cclk) begin
                hi_len++;
                lo_len = 0;
            end else begin
                if (mon_cclk) chk(hi_len == TB_HALF, "R4 high phase length", hi_len, TB_HALF);
                hi_len = 0;
                lo_len++;
            end
            if (!cfg_prog_n) plen++;
            else begin
                if (!mon_prog) begin last_plen = plen; prog_pulses++; end
                plen = 0;
            end
            if (!user_rst_n) rlen++;
            else begin
                if (!mon_urst) begin last_rlen = rlen; rst_pulses++; end
                rlen = 0;
            end
            mon_cclk = cfg_cclk;
            mon_prog = cfg_prog_n;
            mon_urst = user_rst_n;
        end
    end

    // ---------------- driver ----------------
    logic [7:0] pat [0:7];

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // mode: 0 success, 1 crc error, 2 not done, 3 init timeout
    task automatic do_run(input int n, input int mode, input bit poke);
        int b_prog, b_rst, b_rise, b_trail, b_hs;
        b_prog = prog_pulses; b_rst = rst_pulses; b_rise = rises;
        b_trail = trail_seen; b_hs = hs;
        tgt_bits    = 8 * n;
        tgt_never   = (mode == 3);
        tgt_crc     = (mode == 1);
        tgt_done_en = (mode != 2);
        start = 1'b1;
        step();
        start = 1'b0;
        step();
        chk(busy && !load_ok && !fail_timeout && !fail_crc && !fail_notdone,
            "R10 flags cleared while busy", int'(busy), 1);
        if (mode != 3) begin
            for (int i = 0; i < n; i++) begin
                for (int k = 7; k >= 0; k--) exp_q.push_back(pat[i][k]);
                repeat (i) step();
                byte_data  = pat[i];
                byte_last  = (i == n - 1);
                byte_valid = 1'b1;
                while (!byte_ready) step();
                step();
                byte_valid = 1'b0;
                byte_last  = 1'b0;
                if (poke && i == 0) begin
                    start = 1'b1;
                    step();
                    start = 1'b0;
                end
            end
        end
        while (busy) step();
        step();
        chk(prog_pulses - b_prog == 1, "R10 one program pulse per load", prog_pulses - b_prog, 1);
        chk(last_plen == TB_PROG, "R2 program pulse width", last_plen, TB_PROG);
        case (mode)
            0: begin
                chk(load_ok && !fail_crc && !fail_notdone && !fail_timeout, "R9 success flag", int'(load_ok), 1);
                chk(trail_seen - b_trail == TB_TRAIL, "R9 trailing clocks", trail_seen - b_trail, TB_TRAIL);
                chk(rst_pulses - b_rst == 1, "R9 one user reset pulse", rst_pulses - b_rst, 1);
                chk(last_rlen == TB_RST, "R9 user reset width", last_rlen, TB_RST);
                chk(exp_q.size() == 0, "R5 all bits sent", exp_q.size(), 0);
                chk(hs - b_hs == n, "R6 bytes accepted", hs - b_hs, n);
                chk(rises - b_rise == 8 * n + TB_TRAIL, "R5 rising edge count", rises - b_rise, 8 * n + TB_TRAIL);
            end
            1: begin
                chk(fail_crc && !load_ok && !fail_notdone, "R7 crc flag", int'(fail_crc), 1);
                chk(trail_seen - b_trail == 0, "R7 no trailing clocks", trail_seen - b_trail, 0);
                chk(rst_pulses - b_rst == 0, "R7 no user reset", rst_pulses - b_rst, 0);
                chk(exp_q.size() == 0, "R5 all bits sent", exp_q.size(), 0);
            end
            2: begin
                chk(fail_notdone && !load_ok && !fail_crc, "R8 not-done flag", int'(fail_notdone), 1);
                chk(trail_seen - b_trail == 0, "R8 no trailing clocks", trail_seen - b_trail, 0);
                chk(hs - b_hs == n, "R6 bytes accepted", hs - b_hs, n);
            end
            default: begin
                chk(fail_timeout && !load_ok, "R3 timeout flag", int'(fail_timeout), 1);
                chk(rises - b_rise == 0, "R3 no clock on timeout", rises - b_rise, 0);
                chk(hs - b_hs == 0, "R3 no byte requested", hs - b_hs, 0);
            end
        endcase
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) step();
        chk(cfg_prog_n && user_rst_n && !cfg_cclk && !busy && !byte_ready,
            "R1 idle levels in reset", int'(cfg_prog_n), 1);
        rst_n = 1'b1;
        repeat (3) step();
        chk(cfg_prog_n && user_rst_n && !cfg_cclk && !busy && !byte_ready,
            "R1 idle levels after reset", int'(busy), 0);
        chk(!load_ok && !fail_timeout && !fail_crc && !fail_notdone,
            "R1 flags low after reset", int'(load_ok), 0);

        pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'h81;
        do_run(3, 0, 1'b0);

        repeat (15) step();
        chk(load_ok && !busy, "R10 success held while idle", int'(load_ok), 1);

        pat[0] = 8'h01;
        do_run(1, 0, 1'b1);

        pat[0] = 8'hFF; pat[1] = 8'h00;
        do_run(2, 1, 1'b0);
        repeat (10) step();
        chk(fail_crc, "R10 crc flag held", int'(fail_crc), 1);

        pat[0] = 8'h5A; pat[1] = 8'hC3;
        do_run(2, 2, 1'b0);

        do_run(0, 3, 1'b0);

        pat[0] = 8'h12; pat[1] = 8'h34; pat[2] = 8'h56; pat[3] = 8'h80;
        do_run(4, 0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule